// File: doc/BRIEF.md
# Timed Page Write Sequencer with Polling Status

This block gathers single-byte write events into a page buffer and turns them into one timed programming operation. The first write while idle opens a page load. Each later write that stays inside the same page restarts a gap timer. When the timer runs out with no new write, the block goes busy for a programming interval set by a parameter. It then streams every byte that was written out of a commit port, and an external storage array captures those bytes.

A write that addresses a different page while a load is open cancels the whole page, and nothing is committed. The host follows progress through status reads. While the block is busy, a read returns the inverse of the last written byte's top bit, and a toggle bit that flips on every read. Once the block is idle again, a read passes through the data that the array supplies for the read address.

Top module: `page_write_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `cm_valid` and `rd_valid` are low.
- R2: An accepted write while idle opens a page load. `busy` stays low while the load is open.
- R3: Each accepted write in the same page restarts the gap window. A write that arrives no later than GAP_TICKS cycles after the previous accepted write extends the load. `busy` rises in the (GAP_TICKS+1)th cycle after the last accepted write.
- R4: The page is `wr_addr[ADDR_W-1:6]` (the address bits above the 6-bit byte offset). During a load, a write whose page differs from the open page cancels the load: no byte is committed, the block returns to idle, and the offending write is discarded.
- R5: `busy` stays high for at least PROG_TICKS cycles. Each distinct offset written in the page is then committed exactly once with the most recent data written to it, and offsets that were not written are left untouched.
- R6: A write presented while `busy` is high has no effect on the committed contents or on the status value.
- R7: A status read while busy returns bit 7 as the inverse of bit 7 of the last accepted write, and bits 5:0 equal to bits 5:0 of that byte.
- R8: Bit 6 of the status inverts on every status read made while busy. Reads made while not busy do not change it.
- R9: `rd_valid` is high exactly one cycle after `rd_en`. When `busy` was low at the read, `rd_data` equals the value on `rd_arr_data`.
- R10: A full page of PAGE_BYTES writes at consecutive offsets is committed completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write event |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| rd_en | input | 1 | Status/data read request |
| rd_arr_data | input | 8 | Array contents at the read address, supplied from outside |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | rd_data is valid this cycle |
| cm_valid | output | 1 | Commit port carries a byte for the array |
| cm_addr | output | ADDR_W | Array address of the committed byte |
| cm_data | output | 8 | Committed byte value |
| busy | output | 1 | Programming or commit in progress |

## Verification
The checker assumes that the host drives at most one write or one read per cycle. It also assumes that the array data handed back on reads comes from the same array that the commit port fills. The polling assertions assume that writes presented while busy are dropped, so they track the last byte only from writes seen while not busy. The stimulus places random page writes with gaps strictly inside the window and then waits more than the window, so the start of programming always falls in a known cycle. Status reads and extra writes are issued only after `busy` has been seen high, and the next page starts only after `busy` has fallen.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_COMMIT,
    ST_DRAIN
  } pws_state_t;
endpackage

// File: rtl/pws_tick_timer.sv
module pws_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             restart,
  input  logic             clr,
  input  logic [OFF_W-1:0] woff,
  input  logic [7:0]       wdata,
  input  logic [OFF_W-1:0] roff,
  output logic [7:0]       rdata,
  output logic             rbit
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled_q;
  logic [PAGE_BYTES-1:0] fill_set;

  // data store: write port plus registered read, no reset
  always_ff @(posedge clk) begin
    if (we) mem[woff] <= wdata;
    rdata <= mem[roff];
  end

  always_comb begin
    fill_set = restart ? '0 : filled_q;
    fill_set[woff] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled_q <= '0;
      rbit     <= 1'b0;
    end else begin
      if (clr) filled_q <= '0;
      else if (we) filled_q <= fill_set;
      rbit <= filled_q[roff];
    end
  end
endmodule

// File: rtl/pws_status.sv
module pws_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  logic       busy,
  input  logic [7:0] arr_data,
  input  logic [7:0] last_data,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (busy) begin
          rd_data <= {~last_data[7], tog_q, last_data[5:0]};
          tog_q   <= ~tog_q;
        end else begin
          rd_data <= arr_data;
        end
      end
    end
  end
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int GAP_TICKS  = 1000,
  parameter int PROG_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [7:0]        rd_arr_data,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [7:0]        cm_data,
  output logic              busy
);
  import pws_pkg::*;

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int T_MAX  = (GAP_TICKS > PROG_TICKS) ? GAP_TICKS : PROG_TICKS;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  pws_state_t       state_q;
  logic [PG_W-1:0]  page_q;
  logic [7:0]       last_q;
  logic [OFF_W-1:0] idx_q;
  logic [OFF_W-1:0] off_q;
  logic             stg_q;

  logic             accept, same_pg, buf_we, buf_clr, restart;
  logic             tmr_load, tmr_zero, fill_bit;
  logic [CNT_W-1:0] tmr_val;

  assign busy    = (state_q == ST_PROG) || (state_q == ST_COMMIT) || (state_q == ST_DRAIN);
  assign accept  = wr_en && !busy;
  assign same_pg = (wr_addr[ADDR_W-1:OFF_W] == page_q);
  assign restart = (state_q == ST_IDLE);
  assign buf_we  = accept && ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && same_pg));
  assign buf_clr = ((state_q == ST_LOAD) && accept && !same_pg) ||
                   ((state_q == ST_COMMIT) && (idx_q == LAST_OFF));
  assign tmr_load = buf_we || ((state_q == ST_LOAD) && !accept && tmr_zero);
  assign tmr_val  = buf_we ? CNT_W'(GAP_TICKS) : CNT_W'(PROG_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      last_q  <= '0;
      idx_q   <= '0;
    end else begin
      if (accept) last_q <= wr_data;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOAD;
          page_q  <= wr_addr[ADDR_W-1:OFF_W];
        end
        ST_LOAD: begin
          if (accept) begin
            if (!same_pg) state_q <= ST_IDLE;
          end else if (tmr_zero) begin
            state_q <= ST_PROG;
          end
        end
        ST_PROG: begin
          idx_q <= '0;
          if (tmr_zero) state_q <= ST_COMMIT;
        end
        ST_COMMIT: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_OFF) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // commit pipeline stage aligned with the registered buffer read
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= 1'b0;
      off_q <= '0;
    end else begin
      stg_q <= (state_q == ST_COMMIT);
      off_q <= idx_q;
    end
  end

  assign cm_valid = stg_q && fill_bit;
  assign cm_addr  = {page_q, off_q};

  pws_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pws_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .restart(restart), .clr(buf_clr),
    .woff(wr_addr[OFF_W-1:0]), .wdata(wr_data), .roff(idx_q),
    .rdata(cm_data), .rbit(fill_bit)
  );

  pws_status u_stat (
    .clk(clk), .rst(rst), .rd_en(rd_en), .busy(busy), .arr_data(rd_arr_data),
    .last_data(last_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic              cm_valid,
  input logic [ADDR_W-1:0] cm_addr,
  input logic              busy
);
  logic [7:0]             seen_byte;
  logic [ADDR_W-OFF_W-1:0] seen_pg;
  logic                   busy_rd_q, have_q, prev6_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_byte <= '0;
      seen_pg   <= '0;
      busy_rd_q <= 1'b0;
      have_q    <= 1'b0;
      prev6_q   <= 1'b0;
    end else begin
      if (wr_en && !busy) begin
        seen_byte <= wr_data;
        seen_pg   <= wr_addr[ADDR_W-1:OFF_W];
      end
      busy_rd_q <= rd_en && busy;
      if (busy_rd_q) begin
        if (have_q) begin
          p_toggle_flip_r8: assert (rd_data[6] != prev6_q)
            else $error("bit 6 did not invert between busy reads");
        end
        prev6_q <= rd_data[6];
        have_q  <= 1'b1;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy && !cm_valid && !rd_valid));

  p_commit_only_busy_r5: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> busy);

  p_commit_page_r4: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> (cm_addr[ADDR_W-1:OFF_W] == seen_pg));

  p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_poll_bit7_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> ((rd_data[7] == ~seen_byte[7]) && (rd_data[5:0] == seen_byte[5:0])));
endmodule

bind page_write_seq pws_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pws_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .cm_valid(cm_valid), .cm_addr(cm_addr), .busy(busy)
);

// File: tb/page_write_seq_test.sv
module page_write_seq_test;
  localparam int AW   = 10;
  localparam int PB   = 64;
  localparam int GAP  = 12;
  localparam int PROG = 60;
  localparam int NLOC = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_arr_data, rd_data, cm_data;
  logic          rd_valid, cm_valid, busy;
  logic [AW-1:0] cm_addr;

  logic [7:0] arr [NLOC];
  logic [7:0] mdl [NLOC];
  logic [7:0] pend [PB];
  logic       pv [PB];
  int         n_chk = 0, n_err = 0, n_commit = 0;
  logic       exp_tog = 1'b0;
  logic [7:0] last_wr = '0;

  always #4 clk = ~clk;

  assign rd_arr_data = arr[rd_addr];

  page_write_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .GAP_TICKS(GAP), .PROG_TICKS(PROG)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_arr_data(rd_arr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .busy(busy)
  );

  always @(posedge clk) begin
    if (cm_valid) begin
      arr[cm_addr] <= cm_data;
      n_commit <= n_commit + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int count_diff();
    int d = 0;
    for (int i = 0; i < NLOC; i++) if (arr[i] !== mdl[i]) d++;
    return d;
  endfunction

  function automatic int count_pend();
    int c = 0;
    for (int i = 0; i < PB; i++) if (pv[i]) c++;
    return c;
  endfunction

  function automatic logic [7:0] poll_value(input logic [7:0] b, input logic t);
    return {~b[7], t, b[5:0]};
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic clear_pend();
    for (int i = 0; i < PB; i++) begin pv[i] = 1'b0; pend[i] = '0; end
  endtask

  // load one page, then follow the busy period and check the result
  task automatic run_page(input int pg, input int n, input bit full);
    logic [7:0] d, dat;
    logic       v;
    int         off, bcnt, c0;
    clear_pend();
    c0 = n_commit;
    for (int i = 0; i < n; i++) begin
      off = full ? i : int'($urandom_range(PB-1, 0));
      dat = 8'($urandom);
      do_write(AW'(pg * PB + off), dat);
      pend[off] = dat; pv[off] = 1'b1; last_wr = dat;
      if (i == 0) check("R2 busy low during load", 32'(busy), 32'd0);
      if (i != n - 1) repeat ($urandom_range(GAP - 1, 0)) @(negedge clk);
    end
    repeat (GAP) @(negedge clk);
    check("R3 busy low at window end", 32'(busy), 32'd0);
    @(negedge clk);
    check("R3 busy rises after window", 32'(busy), 32'd1);
    bcnt = 1;
    for (int r = 0; r < 3; r++) begin
      do_read(AW'(pg * PB), d, v); bcnt++;
      check("R7 R8 busy status value", 32'(d), 32'(poll_value(last_wr, exp_tog)));
      check("R9 read valid", 32'(v), 32'd1);
      exp_tog = ~exp_tog;
    end
    do_write(AW'(pg * PB + 1), ~last_wr); bcnt++;
    do_write(AW'(((pg + 1) % (NLOC / PB)) * PB), 8'h3C); bcnt++;
    do_read(AW'(pg * PB), d, v); bcnt++;
    check("R6 ignored write keeps status", 32'(d), 32'(poll_value(last_wr, exp_tog)));
    exp_tog = ~exp_tog;
    while (busy && bcnt < 10000) begin @(negedge clk); bcnt++; end
    check("R5 busy at least PROG_TICKS", 32'(bcnt >= PROG), 32'd1);
    for (int i = 0; i < PB; i++) if (pv[i]) mdl[pg * PB + i] = pend[i];
    @(negedge clk);
    check("R5 R6 array contents", 32'(count_diff()), 32'd0);
    check(full ? "R10 full page commit count" : "R5 commit count",
          32'(n_commit - c0), 32'(count_pend()));
    off = int'($urandom_range(NLOC - 1, 0));
    do_read(AW'(off), d, v);
    check("R9 idle read passes array data", 32'(d), 32'(mdl[off]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       v;
    int         c0;
    void'($urandom(32'd1234));
    for (int i = 0; i < NLOC; i++) begin
      arr[i] = 8'(i) ^ 8'h5A;
      mdl[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 commit idle in reset", 32'(cm_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 read valid after reset", 32'(rd_valid), 32'd0);

    // idle read and toggle bit untouched outside busy
    do_read(AW'(77), d, v);
    check("R9 idle read data", 32'(d), 32'(mdl[77]));

    // full page at consecutive offsets
    run_page(3, PB, 1'b1);

    // directed: same offset written twice, latest value must land
    clear_pend();
    c0 = n_commit;
    do_write(AW'(5 * PB + 9), 8'h11);
    do_write(AW'(5 * PB + 9), 8'h96);
    repeat (GAP + 2) @(negedge clk);
    check("R3 busy after short page", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    mdl[5 * PB + 9] = 8'h96;
    @(negedge clk);
    check("R5 last data wins", 32'(arr[5 * PB + 9]), 32'h96);
    check("R5 single commit for repeated offset", 32'(n_commit - c0), 32'd1);

    // cancel: leave the page mid-load
    c0 = n_commit;
    do_write(AW'(2 * PB + 1), 8'hA1);
    do_write(AW'(2 * PB + 2), 8'hA2);
    do_write(AW'(7 * PB + 4), 8'hA7);
    repeat (GAP + PROG + PB + 10) @(negedge clk);
    check("R4 no programming after cancel", 32'(busy), 32'd0);
    check("R4 no commits after cancel", 32'(n_commit - c0), 32'd0);
    check("R4 array untouched after cancel", 32'(count_diff()), 32'd0);

    // random pages
    for (int p = 0; p < 6; p++)
      run_page(int'($urandom_range(NLOC / PB - 1, 0)), int'($urandom_range(40, 1)), 1'b0);

    // toggle bit does not move across idle reads
    do_read(AW'(3), d, v);
    check("R9 idle read after pages", 32'(d), 32'(mdl[3]));
    run_page(1, 4, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule